// File: doc/BRIEF.md
# Backlight Dimming Pulse-Width Modulator

This block drives one pulse-width-modulated line, typically the dimming input of a display backlight. Software programs three timing fields through a small register bank: a prescaler divisor, a period length counted in prescaled ticks, and a high time counted in the same ticks. The output period is (divider+1)×(period+1) input clock cycles. The output is high for the first (divider+1)×high_width cycles of each period.

Timing writes land in staged copies and do nothing on their own. Software writes the commit bit from 0 to 1 to snapshot the staged values. The running generator adopts the snapshot at its next period boundary, so a reprogramming never leaves a truncated or stretched pulse on the pin. A separate run bit starts and stops the output. Each start begins a fresh period, with the output high.

Top module: `bl_pwm_top`

## Requirements
- R1: After reset the block is stopped, `pwm_out` is low, and every register reads 0.
- R2: Register map (byte offsets on `bus_addr`): 0x00 bit 0 = run; 0x08 bit 0 = commit; 0x10 bits 25:16 = divider; 0x14 bits 11:0 = period and bits 28:16 = high width. Unmapped bits and unmapped offsets read 0, and writes to them are dropped.
- R3: A read returns the staged value of a field, whether or not that value has been committed.
- R4: While running with committed settings, each output period lasts (divider+1)×(period+1) clock cycles, including divider 0x3FF and period 0xFFF.
- R5: While running, the output is high for (divider+1)×high_width cycles at the start of each period, when 1 ≤ high_width ≤ period.
- R6: Writing the divider, period or width without a commit leaves the output waveform unchanged.
- R7: A write that takes the commit bit from 0 to 1 snapshots the staged fields. While running, the active settings change only at a period boundary, so every completed high or low interval has the length of either the old setting or the new one. Once the first new period starts, only new-setting intervals follow.
- R8: If high_width ≥ period+1 the output stays high for the whole period. If high_width is 0 the output stays low.
- R9: Writing 0 to the run bit drives `pwm_out` low from the next cycle on.
- R10: A commit made while stopped takes effect at once. Writing 1 to the run bit starts a fresh period: in the next cycle `pwm_out` is high exactly when high_width is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register of the block updates on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | 5 | Byte offset of the register for a read or a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench builds the block with its default widths: a 10-bit divider, a 12-bit period and a 13-bit width. With these widths the largest divider and the longest period are each one directed run of a few thousand cycles. The random cases use small dividers and periods, so many timing settings fit in the budget. The default 13-bit width field can also exceed period+1, which reaches the saturated always-high case. A monitor records the length of every high and low interval on the pin. The bench compares these lengths with the formulas, including across a reprogramming, where a mid-period switch would show up as an interval of a length that neither setting produces.

// File: rtl/bl_pwm_pkg.sv
// Package: shared register offsets, field positions and address decode for
// the backlight PWM block. Assumes a 32-bit data bus and byte offsets that
// fit in five address bits.
package bl_pwm_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;

    // Register offsets (byte addresses).
    localparam logic [ADDR_W-1:0] OFS_RUN   = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_LATCH = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_PRESC = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_SHAPE = 5'h14;

    // Lowest bit of the divider field and of the width field.
    localparam int PRESC_LSB = 16;
    localparam int WIDTH_LSB = 16;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RUN,
        SEL_LATCH,
        SEL_PRESC,
        SEL_SHAPE
    } reg_sel_e;

    // Maps a byte offset to the register it selects.
    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_RUN:   return SEL_RUN;
            OFS_LATCH: return SEL_LATCH;
            OFS_PRESC: return SEL_PRESC;
            OFS_SHAPE: return SEL_SHAPE;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/bl_pwm_regs.sv
// Module: register bank. Holds the run bit, the commit bit and the staged
// timing fields, serves combinational reads of the staged values, and emits
// a one-cycle pulse when a write takes the commit bit from 0 to 1.
// Assumes the field widths fit above their LSB inside the data bus.
module bl_pwm_regs
    import bl_pwm_pkg::*;
#(
    parameter int DIV_W = 10,
    parameter int PER_W = 12,
    parameter int HI_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              run_en,
    output logic              commit_pulse,
    output logic [DIV_W-1:0]  stg_div,
    output logic [PER_W-1:0]  stg_per,
    output logic [HI_W-1:0]   stg_hi
);

    reg_sel_e sel;
    logic     latch_q;
    logic     unused_wdata;

    assign sel          = decode_sel(bus_addr);
    assign unused_wdata = ^bus_wdata;

    // Register writes: only the defined fields are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en  <= 1'b0;
            latch_q <= 1'b0;
            stg_div <= '0;
            stg_per <= '0;
            stg_hi  <= '0;
        end else if (bus_wr) begin
            case (sel)
                SEL_RUN:   run_en  <= bus_wdata[0];
                SEL_LATCH: latch_q <= bus_wdata[0];
                SEL_PRESC: stg_div <= bus_wdata[PRESC_LSB +: DIV_W];
                SEL_SHAPE: begin
                    stg_per <= bus_wdata[PER_W-1:0];
                    stg_hi  <= bus_wdata[WIDTH_LSB +: HI_W];
                end
                default: ;
            endcase
        end
    end

    // Commit event: a write of 1 while the stored commit bit is 0.
    assign commit_pulse = bus_wr && (sel == SEL_LATCH) && bus_wdata[0] && !latch_q;

    // Read mux: staged values in their field positions, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_RUN:   bus_rdata[0] = run_en;
            SEL_LATCH: bus_rdata[0] = latch_q;
            SEL_PRESC: bus_rdata[PRESC_LSB +: DIV_W] = stg_div;
            SEL_SHAPE: begin
                bus_rdata[PER_W-1:0]         = stg_per;
                bus_rdata[WIDTH_LSB +: HI_W] = stg_hi;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bl_pwm_shadow.sv
// Module: settings pipeline. On a commit pulse it snapshots the staged
// fields into a pending copy. It moves the pending copy into the active copy
// at a period boundary, or at once while the generator is stopped.
// Assumes period_end is high only in the last cycle of a running period.
module bl_pwm_shadow #(
    parameter int DIV_W = 10,
    parameter int PER_W = 12,
    parameter int HI_W  = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_pulse,
    input  logic             run_en,
    input  logic             period_end,
    input  logic [DIV_W-1:0] stg_div,
    input  logic [PER_W-1:0] stg_per,
    input  logic [HI_W-1:0]  stg_hi,
    output logic [DIV_W-1:0] act_div,
    output logic [PER_W-1:0] act_per,
    output logic [HI_W-1:0]  act_hi
);

    logic             pend_q;
    logic [DIV_W-1:0] pend_div;
    logic [PER_W-1:0] pend_per;
    logic [HI_W-1:0]  pend_hi;
    logic             take;

    assign take = pend_q && (period_end || !run_en);

    // Pending copy: filled on commit, released when the active copy takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            pend_div <= '0;
            pend_per <= '0;
            pend_hi  <= '0;
        end else if (commit_pulse) begin
            pend_q   <= 1'b1;
            pend_div <= stg_div;
            pend_per <= stg_per;
            pend_hi  <= stg_hi;
        end else if (take) begin
            pend_q   <= 1'b0;
        end
    end

    // Active copy: changes only when a pending snapshot is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_div <= '0;
            act_per <= '0;
            act_hi  <= '0;
        end else if (take) begin
            act_div <= pend_div;
            act_per <= pend_per;
            act_hi  <= pend_hi;
        end
    end

endmodule

// File: rtl/bl_pwm_gen.sv
// Module: waveform generator. A prescaler counts input clocks up to the
// divider, a period counter counts prescaled ticks up to the period, and the
// output is high while the tick count is below the high width. Stopped
// means both counters are held at 0 and the output is low.
// Assumes the active settings change only at a period boundary or while stopped.
module bl_pwm_gen #(
    parameter int DIV_W = 10,
    parameter int PER_W = 12,
    parameter int HI_W  = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [DIV_W-1:0] act_div,
    input  logic [PER_W-1:0] act_per,
    input  logic [HI_W-1:0]  act_hi,
    output logic [DIV_W-1:0] presc_q,
    output logic [PER_W-1:0] cnt_q,
    output logic             period_end,
    output logic             pwm_out
);

    localparam int CMP_W = ((PER_W > HI_W) ? PER_W : HI_W) + 1;
    localparam logic [DIV_W-1:0] DIV_ONE = 1;
    localparam logic [PER_W-1:0] PER_ONE = 1;

    logic tick_end;

    assign tick_end   = (presc_q == act_div);
    assign period_end = run_en && tick_end && (cnt_q == act_per);

    // Counters: prescaler wraps at the divider, period counter at the period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            presc_q <= '0;
            cnt_q   <= '0;
        end else if (tick_end) begin
            presc_q <= '0;
            cnt_q   <= (cnt_q == act_per) ? '0 : cnt_q + PER_ONE;
        end else begin
            presc_q <= presc_q + DIV_ONE;
        end
    end

    // Output compare: high while the tick count is below the high width.
    assign pwm_out = run_en && (CMP_W'(cnt_q) < CMP_W'(act_hi));

endmodule

// File: rtl/bl_pwm_top.sv
// Module: top level of the backlight PWM. Connects the register bank, the
// commit pipeline and the waveform generator. Assumes a single clock domain
// and a synchronous active-low reset.
module bl_pwm_top
    import bl_pwm_pkg::*;
#(
    parameter int DIV_W = 10,
    parameter int PER_W = 12,
    parameter int HI_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out
);

    logic             run_en;
    logic             commit_pulse;
    logic             period_end;
    logic [DIV_W-1:0] stg_div, act_div, presc_q;
    logic [PER_W-1:0] stg_per, act_per, cnt_q;
    logic [HI_W-1:0]  stg_hi, act_hi;

    bl_pwm_regs #(.DIV_W(DIV_W), .PER_W(PER_W), .HI_W(HI_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .run_en(run_en),
        .commit_pulse(commit_pulse), .stg_div(stg_div), .stg_per(stg_per),
        .stg_hi(stg_hi)
    );

    bl_pwm_shadow #(.DIV_W(DIV_W), .PER_W(PER_W), .HI_W(HI_W)) shadow_i (
        .clk(clk), .rst_n(rst_n), .commit_pulse(commit_pulse),
        .run_en(run_en), .period_end(period_end), .stg_div(stg_div),
        .stg_per(stg_per), .stg_hi(stg_hi), .act_div(act_div),
        .act_per(act_per), .act_hi(act_hi)
    );

    bl_pwm_gen #(.DIV_W(DIV_W), .PER_W(PER_W), .HI_W(HI_W)) gen_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .act_div(act_div),
        .act_per(act_per), .act_hi(act_hi), .presc_q(presc_q),
        .cnt_q(cnt_q), .period_end(period_end), .pwm_out(pwm_out)
    );

endmodule

// File: rtl/bl_pwm_chk.sv
// Module: assertion checker for bl_pwm_top, attached by bind below.
// Assumes the default field positions of bl_pwm_pkg.
module bl_pwm_chk
    import bl_pwm_pkg::*;
#(
    parameter int DIV_W = 10,
    parameter int PER_W = 12,
    parameter int HI_W  = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              pwm_out,
    input logic              run_en,
    input logic              period_end,
    input logic [DIV_W-1:0]  act_div,
    input logic [PER_W-1:0]  act_per,
    input logic [HI_W-1:0]   act_hi,
    input logic [DIV_W-1:0]  presc_q,
    input logic [PER_W-1:0]  cnt_q
);

    localparam int CMP_W = ((PER_W > HI_W) ? PER_W : HI_W) + 1;

    // R9: a stop write forces the output low in the next cycle.
    a_r9_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_RUN && !bus_wdata[0]) |=> !pwm_out);

    // R10: a start write begins a period, high exactly when the width is nonzero.
    a_r10_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_RUN && bus_wdata[0] && !run_en)
        |=> (pwm_out == (act_hi != '0)));

    // R7: while running, the active settings hold except at a period boundary.
    a_r7_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !period_end)
        |=> ($stable(act_div) && $stable(act_per) && $stable(act_hi)));

    // R4: the counters stay inside the active divider and period.
    a_r4_counter_range: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |-> (presc_q <= act_div && cnt_q <= act_per));

    // R8: a width beyond the period keeps the output high while running.
    a_r8_saturate_high: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && CMP_W'(act_hi) > CMP_W'(act_per)) |-> pwm_out);

    // R8: a zero width keeps the output low.
    a_r8_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (act_hi == '0) |-> !pwm_out);

endmodule

bind bl_pwm_top bl_pwm_chk #(.DIV_W(DIV_W), .PER_W(PER_W), .HI_W(HI_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pwm_out(pwm_out), .run_en(run_en),
    .period_end(period_end), .act_div(act_div), .act_per(act_per),
    .act_hi(act_hi), .presc_q(presc_q), .cnt_q(cnt_q)
);

// File: tb/bl_pwm_top_tb_top.sv
// Bench for bl_pwm_top: directed corner cases plus seeded random timing
// settings, checked against interval lengths computed from the requirements.
module bl_pwm_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    localparam logic [4:0] A_RUN   = 5'h00;
    localparam logic [4:0] A_LATCH = 5'h08;
    localparam logic [4:0] A_PRESC = 5'h10;
    localparam logic [4:0] A_SHAPE = 5'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Interval log: level and length of every completed run on pwm_out.
    bit lvl_q[$];
    int len_q[$];
    bit cur_lvl = 1'b0;
    int cur_len = 0;

    bl_pwm_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: samples 1 time unit after each rising edge and logs runs.
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            cur_lvl = 1'b0;
            cur_len = 0;
        end else if (pwm_out == cur_lvl) begin
            cur_len++;
        end else begin
            lvl_q.push_back(cur_lvl);
            len_q.push_back(cur_len);
            cur_lvl = pwm_out;
            cur_len = 1;
        end
    end

    function automatic int high_len(int d, int h);
        return (d + 1) * h;
    endfunction

    function automatic int low_len(int d, int p, int h);
        return (d + 1) * (p + 1 - h);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic stage(int d, int p, int h);
        bus_write(A_PRESC, 32'(d) << 16);
        bus_write(A_SHAPE, (32'(h) << 16) | 32'(p));
    endtask

    task automatic commit();
        bus_write(A_LATCH, 32'd1);
        bus_write(A_LATCH, 32'd0);
    endtask

    task automatic wait_runs(int n);
        while (len_q.size() < n) @(negedge clk);
    endtask

    // Stopped: configure, commit, start, then check the first period.
    task automatic run_case(int d, int p, int h, string tag);
        int base;
        bus_write(A_RUN, 32'd0);
        stage(d, p, h);
        commit();
        bus_write(A_RUN, 32'd1);
        check(pwm_out == 1'b1, {tag, " R10 start high"}, int'(pwm_out), 1);
        base = len_q.size();
        wait_runs(base + 2);
        check(lvl_q[base] == 1'b1 && len_q[base] == high_len(d, h),
              {tag, " R5 high time"}, len_q[base], high_len(d, h));
        check(lvl_q[base+1] == 1'b0 && len_q[base+1] == low_len(d, p, h),
              {tag, " R4 period low part"}, len_q[base+1], low_len(d, p, h));
        bus_write(A_RUN, 32'd0);
        check(pwm_out == 1'b0, {tag, " R9 stop low"}, int'(pwm_out), 0);
    endtask

    // Runs with a constant expected level for n cycles.
    task automatic steady_case(int d, int p, int h, bit lvl, string tag);
        int bad;
        bad = 0;
        bus_write(A_RUN, 32'd0);
        stage(d, p, h);
        commit();
        bus_write(A_RUN, 32'd1);
        for (int i = 0; i < 4 * (d + 1) * (p + 1); i++) begin
            if (pwm_out != lvl) bad++;
            @(negedge clk);
        end
        check(bad == 0, {tag, " R8 steady level"}, bad, 0);
        bus_write(A_RUN, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int base, ok, d, p, h;
        void'($urandom(32'h5EED_0042));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        check(pwm_out == 1'b0, "R1 output low", int'(pwm_out), 0);
        bus_read(A_RUN, rd);   check(rd == 0, "R1 run reg", rd, 0);
        bus_read(A_LATCH, rd); check(rd == 0, "R1 commit reg", rd, 0);
        bus_read(A_PRESC, rd); check(rd == 0, "R1 divider reg", rd, 0);
        bus_read(A_SHAPE, rd); check(rd == 0, "R1 shape reg", rd, 0);

        // R2 / R3: field masks and staged readback.
        bus_write(A_PRESC, 32'hFFFF_FFFF);
        bus_read(A_PRESC, rd); check(rd == 32'h03FF_0000, "R2 divider mask", rd, 32'h03FF_0000);
        bus_write(A_SHAPE, 32'hFFFF_FFFF);
        bus_read(A_SHAPE, rd); check(rd == 32'h1FFF_0FFF, "R2 shape mask", rd, 32'h1FFF_0FFF);
        bus_write(A_RUN, 32'hFFFF_FFFF);
        bus_read(A_RUN, rd);   check(rd == 32'h1, "R2 run mask", rd, 1);
        bus_write(A_RUN, 32'h0);
        bus_write(A_LATCH, 32'hFFFF_FFFE);
        bus_read(A_LATCH, rd); check(rd == 32'h0, "R2 commit mask", rd, 0);
        bus_write(5'h04, 32'hFFFF_FFFF);
        bus_read(5'h04, rd);   check(rd == 0, "R2 unmapped 0x04", rd, 0);
        bus_read(5'h0C, rd);   check(rd == 0, "R2 unmapped 0x0C", rd, 0);
        stage(7, 300, 45);
        bus_read(A_PRESC, rd); check(rd == (32'd7 << 16), "R3 staged divider", rd, 32'd7 << 16);
        bus_read(A_SHAPE, rd); check(rd == ((32'd45 << 16) | 32'd300), "R3 staged shape", rd, (32'd45 << 16) | 32'd300);

        // R4 / R5 / R10 directed corners.
        run_case(0, 1, 1, "fastest");
        run_case(1023, 2, 1, "max divider");
        run_case(0, 4095, 4095, "max period");
        run_case(3, 9, 9, "width equals period");

        // R4 / R5 random settings.
        for (int k = 0; k < 12; k++) begin
            d = $urandom_range(0, 5);
            p = $urandom_range(1, 30);
            h = $urandom_range(1, p);
            run_case(d, p, h, $sformatf("random %0d", k));
        end

        // R8: saturated and zero width.
        steady_case(2, 5, 6, 1'b1, "width p+1");
        steady_case(0, 7, 8191, 1'b1, "width max");
        steady_case(1, 5, 0, 1'b0, "width zero");

        // R6: staged writes without commit leave the waveform alone.
        bus_write(A_RUN, 32'd0);
        stage(1, 9, 4);
        commit();
        bus_write(A_RUN, 32'd1);
        wait_runs(len_q.size() + 2);
        stage(0, 4, 2);
        bus_read(A_SHAPE, rd); check(rd == ((32'd2 << 16) | 32'd4), "R3 staged while running", rd, (32'd2 << 16) | 32'd4);
        base = len_q.size();
        wait_runs(base + 6);
        ok = 1;
        for (int i = base + 1; i < base + 6; i++)
            if (len_q[i] != (lvl_q[i] ? 8 : 12)) ok = 0;
        check(ok == 1, "R6 no change without commit", len_q[base+1], lvl_q[base+1] ? 8 : 12);

        // R7: commit while running switches on a boundary only.
        base = len_q.size();
        commit();
        wait_runs(base + 10);
        ok = 1;
        for (int i = base; i < base + 10; i++) begin
            if (lvl_q[i] && !(len_q[i] == 8 || len_q[i] == 2)) ok = 0;
            if (!lvl_q[i] && !(len_q[i] == 12 || len_q[i] == 3)) ok = 0;
        end
        check(ok == 1, "R7 whole intervals only", len_q[base], 8);
        check(len_q[base+8] == (lvl_q[base+8] ? 2 : 3), "R7 new high/low",
              len_q[base+8], lvl_q[base+8] ? 2 : 3);
        check(len_q[base+9] == (lvl_q[base+9] ? 2 : 3), "R7 new period",
              len_q[base+9], lvl_q[base+9] ? 2 : 3);
        bus_write(A_RUN, 32'd0);
        check(pwm_out == 1'b0, "R9 final stop", int'(pwm_out), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule